// File: doc/BRIEF.md
# Microcoded Register-Operation Sequencer

This block executes 16-bit instruction words one step at a time against a 32-entry, 16-bit register file. The register file sits outside the block and is reached through a single shared port: one address, a read enable with same-cycle read data, and a write enable with write data. The top six bits of each word are the opcode. The opcode selects an entry point in a small microcode ROM. Each microcode word sets the control lines for one cycle: read, write, address source, load of the holding register, data-path choice and end of sequence.

Two instruction classes are executed. A register copy reads the source register into an internal holding register and then writes that value to the destination register. A bit set/clear reads a register, sets or clears one selected bit in the holding copy, and writes the result back to the same register. Any other opcode finishes in a single step, raises an illegal-opcode flag and touches no register.

Instructions arrive on a valid/ready handshake. The block accepts a word only while idle, and it is ready again in the cycle after the last microcode step.

Top module: `uop_regseq`

## Requirements
- R1: `instr_ready` is high only while the block is idle. A word is accepted in a cycle where `instr_valid` and `instr_ready` are both high. `instr_ready` is low in the cycle after acceptance and in every cycle in which the register port is in use.
- R2: Copy (opcode 6'b000001, source index in bits [9:5], destination index in bits [4:0]). In the first cycle after acceptance, `rf_rd_en`=1, `rf_wr_en`=0 and `rf_addr`=source. In the second cycle, `rf_wr_en`=1, `rf_rd_en`=0, `rf_addr`=destination, and `rf_wdata` equals the value read in the first cycle.
- R3: Bit set/clear (opcode 6'b000010) with action bit [9]=1 writes back the register read, with bit index [8:5] forced to 1.
- R4: Bit set/clear with action bit [9]=0 writes back the register read, with bit index [8:5] forced to 0.
- R5: Bit set/clear reads register [4:0] in the first cycle and writes the same register in the second cycle. The written value differs from the value read in at most the indexed bit.
- R6: Any opcode other than the two above gives one cycle with `done`=1 and `illegal_op`=1 and no read or write. `illegal_op` is never high outside such a cycle.
- R7: A copy whose source and destination are the same register still performs both the read step and the write step, and leaves that register's value unchanged.
- R8: `rf_rd_en` and `rf_wr_en` are never high in the same cycle.
- R9: `done` is high only in the last step of an instruction: cycle 2 for copy and set/clear, cycle 1 for an illegal opcode. `instr_ready` is high in the cycle after `done`.
- R10: After reset, the block is idle with `instr_ready`=1 and `rf_rd_en`, `rf_wr_en`, `done` and `illegal_op` all 0.
- R11: The instruction word is captured when it is accepted. Changes on `instr_word` while an instruction is running have no effect on the addresses or data it produces.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| instr_valid | input | 1 | Instruction word offered |
| instr_word | input | 16 | Instruction word |
| instr_ready | output | 1 | Block idle and able to accept a word |
| rf_addr | output | 5 | Register file address |
| rf_rd_en | output | 1 | Register read strobe |
| rf_rdata | input | 16 | Register read data, valid in the same cycle as the address |
| rf_wr_en | output | 1 | Register write strobe |
| rf_wdata | output | 16 | Register write data |
| done | output | 1 | Last microcode step of the current instruction |
| illegal_op | output | 1 | The instruction completing this cycle had an unknown opcode |

## Verification
A wrong micro-program counter or a wrong ROM entry shows up on the register port within one or two cycles of acceptance, as a wrong address, a missing strobe or a `done` in the wrong cycle. A corrupted holding register or bit mask shows up as wrong `rf_wdata` in the write step, and it also leaves a wrong value in the modelled register file, which the bench compares after every instruction. A state machine stuck in the running state shows up as `instr_ready` staying low in the cycle after `done`.

// File: rtl/uop_pkg.sv
package uop_pkg;
  localparam int IW     = 16;
  localparam int OPC_W  = 6;
  localparam int AREG_W = 5;
  localparam int DATA_W = 16;
  localparam int UPC_W  = 3;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int ACT_POS = IW - OPC_W - 1;

  localparam logic [OPC_W-1:0] OPC_COPY  = 6'b000001;
  localparam logic [OPC_W-1:0] OPC_BITOP = 6'b000010;

  localparam logic [UPC_W-1:0] UPC_ILL  = 3'd0;
  localparam logic [UPC_W-1:0] UPC_COPY = 3'd1;
  localparam logic [UPC_W-1:0] UPC_BIT  = 3'd3;

  typedef enum logic { ASEL_SRC = 1'b0, ASEL_DST = 1'b1 } asel_e;
  typedef enum logic { DP_PASS = 1'b0, DP_MODIFY = 1'b1 } dpsel_e;
  typedef enum logic { ST_IDLE = 1'b0, ST_RUN = 1'b1 } state_e;

  typedef struct packed {
    logic   rd_en;
    logic   wr_en;
    asel_e  asel;
    logic   hold_ld;
    dpsel_e dp_sel;
    logic   eos;
  } uword_t;
endpackage

// File: rtl/uop_rst_sync.sv
module uop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ni = sync_q[STAGES-1];
endmodule

// File: rtl/uop_rom.sv
module uop_rom
  import uop_pkg::*;
#(
  parameter int OW = OPC_W,
  parameter int PW = UPC_W
) (
  input  logic [OW-1:0] opcode,
  input  logic [PW-1:0] upc,
  output logic [PW-1:0] entry_upc,
  output logic          entry_ill,
  output uword_t        uw
);
  // entry point lookup
  always_comb begin
    entry_ill = 1'b0;
    unique case (opcode)
      OPC_COPY:  entry_upc = PW'(UPC_COPY);
      OPC_BITOP: entry_upc = PW'(UPC_BIT);
      default: begin
        entry_upc = PW'(UPC_ILL);
        entry_ill = 1'b1;
      end
    endcase
  end

  // microcode words
  always_comb begin
    uw.rd_en   = 1'b0;
    uw.wr_en   = 1'b0;
    uw.asel    = ASEL_SRC;
    uw.hold_ld = 1'b0;
    uw.dp_sel  = DP_PASS;
    uw.eos     = 1'b1;
    unique case (upc)
      PW'(0): begin
        uw.eos = 1'b1;
      end
      PW'(1): begin
        uw.rd_en   = 1'b1;
        uw.asel    = ASEL_SRC;
        uw.hold_ld = 1'b1;
        uw.eos     = 1'b0;
      end
      PW'(2): begin
        uw.wr_en  = 1'b1;
        uw.asel   = ASEL_DST;
        uw.dp_sel = DP_PASS;
        uw.eos    = 1'b1;
      end
      PW'(3): begin
        uw.rd_en   = 1'b1;
        uw.asel    = ASEL_DST;
        uw.hold_ld = 1'b1;
        uw.eos     = 1'b0;
      end
      PW'(4): begin
        uw.wr_en  = 1'b1;
        uw.asel   = ASEL_DST;
        uw.dp_sel = DP_MODIFY;
        uw.eos    = 1'b1;
      end
      default: begin
        uw.eos = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/uop_ctrl.sv
module uop_ctrl
  import uop_pkg::*;
#(
  parameter int W  = IW,
  parameter int PW = UPC_W
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          instr_valid,
  input  logic [W-1:0]  instr_word,
  input  logic [PW-1:0] entry_upc,
  input  logic          entry_ill,
  input  uword_t        uw,
  output logic          instr_ready,
  output logic [PW-1:0] upc,
  output logic [W-1:0]  ir,
  output logic          rd_en,
  output logic          wr_en,
  output logic          hold_ld,
  output logic          done,
  output logic          illegal_op
);
  state_e        state_q, state_d;
  logic [PW-1:0] upc_q, upc_d;
  logic [W-1:0]  ir_q;
  logic          ill_q, ill_d;
  logic          accept, running;

  assign running     = (state_q == ST_RUN);
  assign instr_ready = (state_q == ST_IDLE);
  assign accept      = instr_ready & instr_valid;

  // next state
  always_comb begin
    state_d = state_q;
    upc_d   = upc_q;
    ill_d   = ill_q;
    unique case (state_q)
      ST_IDLE: begin
        if (instr_valid) begin
          state_d = ST_RUN;
          upc_d   = entry_upc;
          ill_d   = entry_ill;
        end
      end
      ST_RUN: begin
        if (uw.eos) state_d = ST_IDLE;
        else        upc_d   = upc_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      upc_q   <= '0;
      ill_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      upc_q   <= upc_d;
      ill_q   <= ill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     ir_q <= '0;
    else if (accept) ir_q <= instr_word;
  end

  assign upc        = upc_q;
  assign ir         = ir_q;
  assign rd_en      = running & uw.rd_en;
  assign wr_en      = running & uw.wr_en;
  assign hold_ld    = running & uw.hold_ld;
  assign done       = running & uw.eos;
  assign illegal_op = done & ill_q;

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_ni)
    !(rd_en && wr_en)); // R8
  AST_PORT_BUSY: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_en || wr_en) |-> !instr_ready); // R1
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_ni)
    (instr_valid && instr_ready) |=> !instr_ready); // R1
  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> instr_ready); // R9
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en |-> $past(rd_en)); // R2
  AST_ILL_QUIET: assert property (@(posedge clk) disable iff (!rst_ni)
    illegal_op |-> (done && !rd_en && !wr_en && $past(instr_ready))); // R6
endmodule

// File: rtl/uop_datapath.sv
module uop_datapath
  import uop_pkg::*;
#(
  parameter int W  = IW,
  parameter int DW = DATA_W,
  parameter int AW = AREG_W
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic [W-1:0]  ir,
  input  uword_t        uw,
  input  logic          hold_ld,
  input  logic          wr_en,
  input  logic [DW-1:0] rf_rdata,
  output logic [AW-1:0] rf_addr,
  output logic [DW-1:0] rf_wdata
);
  localparam int XW = $clog2(DW);
  localparam int AP = W - OPC_W - 1;

  logic [AW-1:0] src_f, dst_f;
  logic [XW-1:0] idx_f;
  logic          act_f;
  logic [DW-1:0] hold_q, mask, modified;

  assign src_f = ir[2*AW-1:AW];
  assign dst_f = ir[AW-1:0];
  assign idx_f = ir[AW+XW-1:AW];
  assign act_f = ir[AP];

  // one-hot bit mask
  for (genvar b = 0; b < DW; b++) begin : g_mask
    assign mask[b] = (idx_f == XW'(b));
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      hold_q <= '0;
    else if (hold_ld) hold_q <= rf_rdata;
  end

  always_comb begin
    if (act_f) modified = hold_q | mask;
    else       modified = hold_q & ~mask;
  end

  assign rf_addr  = (uw.asel == ASEL_DST) ? dst_f : src_f;
  assign rf_wdata = (uw.dp_sel == DP_MODIFY) ? modified : hold_q;

  AST_ONE_BIT_DIFF: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && uw.dp_sel == DP_MODIFY) |-> ($countones(rf_wdata ^ hold_q) <= 1)); // R5
  AST_COPY_DATA: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && uw.dp_sel == DP_PASS) |-> (rf_wdata == $past(rf_rdata))); // R2
endmodule

// File: rtl/uop_regseq.sv
module uop_regseq
  import uop_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 instr_valid,
  input  logic [IW-1:0]        instr_word,
  output logic                 instr_ready,
  output logic [AREG_W-1:0]    rf_addr,
  output logic                 rf_rd_en,
  input  logic [DATA_W-1:0]    rf_rdata,
  output logic                 rf_wr_en,
  output logic [DATA_W-1:0]    rf_wdata,
  output logic                 done,
  output logic                 illegal_op
);
  logic             rst_ni;
  logic [UPC_W-1:0] upc, entry_upc;
  logic             entry_ill;
  logic [IW-1:0]    ir;
  logic             hold_ld;
  uword_t           uw;

  uop_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  uop_rom #(.OW(OPC_W), .PW(UPC_W)) u_rom (
    .opcode    (instr_word[IW-1:IW-OPC_W]),
    .upc       (upc),
    .entry_upc (entry_upc),
    .entry_ill (entry_ill),
    .uw        (uw)
  );

  uop_ctrl #(.W(IW), .PW(UPC_W)) u_ctrl (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .entry_upc   (entry_upc),
    .entry_ill   (entry_ill),
    .uw          (uw),
    .instr_ready (instr_ready),
    .upc         (upc),
    .ir          (ir),
    .rd_en       (rf_rd_en),
    .wr_en       (rf_wr_en),
    .hold_ld     (hold_ld),
    .done        (done),
    .illegal_op  (illegal_op)
  );

  uop_datapath #(.W(IW), .DW(DATA_W), .AW(AREG_W)) u_dp (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .ir       (ir),
    .uw       (uw),
    .hold_ld  (hold_ld),
    .wr_en    (rf_wr_en),
    .rf_rdata (rf_rdata),
    .rf_addr  (rf_addr),
    .rf_wdata (rf_wdata)
  );
endmodule

// File: tb/sim_uop_regseq.sv
module sim_uop_regseq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [15:0] instr_word = '0;
  logic        instr_ready, rf_rd_en, rf_wr_en, done, illegal_op;
  logic [4:0]  rf_addr;
  logic [15:0] rf_rdata, rf_wdata;

  logic        pre_we = 1'b0;
  logic [4:0]  pre_a = '0;
  logic [15:0] pre_d = '0;
  logic [15:0] rf  [0:31];
  logic [15:0] exp_rf [0:31];

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uop_regseq u0 (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .instr_ready(instr_ready), .rf_addr(rf_addr), .rf_rd_en(rf_rd_en),
    .rf_rdata(rf_rdata), .rf_wr_en(rf_wr_en), .rf_wdata(rf_wdata),
    .done(done), .illegal_op(illegal_op)
  );

  // register file model
  assign rf_rdata = rf[rf_addr];
  always @(posedge clk) begin
    if (rf_wr_en)    rf[rf_addr] <= rf_wdata;
    else if (pre_we) rf[pre_a]   <= pre_d;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] bit_apply(input logic [15:0] old, input logic act,
                                            input logic [3:0] idx);
    logic [15:0] r;
    r = old;
    r[idx] = act;
    return r;
  endfunction

  function automatic logic [15:0] mk_copy(input int s, input int d);
    return {6'b000001, 5'(s), 5'(d)};
  endfunction

  function automatic logic [15:0] mk_bit(input bit a, input int idx, input int r);
    return {6'b000010, a, 4'(idx), 5'(r)};
  endfunction

  task automatic exec(input logic [15:0] w, input string tag);
    logic [5:0]  op;
    logic [4:0]  s, d;
    logic [15:0] expw;
    string       rq;
    op = w[15:10]; s = w[9:5]; d = w[4:0];
    while (!instr_ready) @(negedge clk);
    instr_valid = 1'b1;
    instr_word  = w;
    @(negedge clk);
    instr_valid = 1'b0;
    instr_word  = 16'($urandom);  // R11: scrambled while running
    chk(!instr_ready, "R1", {tag, " ready low after accept"}, int'(instr_ready), 0);
    if (op == 6'b000001) begin
      rq = (s == d) ? "R7" : "R2";
      expw = exp_rf[s];
      chk(rf_rd_en && !rf_wr_en && rf_addr == s && !done, rq, {tag, " copy read step"},
          int'({rf_rd_en, rf_wr_en, done, rf_addr}), int'({3'b100, s}));
      @(negedge clk);
      chk(rf_wr_en && !rf_rd_en && rf_addr == d && done && !illegal_op, "R9",
          {tag, " copy write step"}, int'({rf_wr_en, rf_rd_en, done, illegal_op, rf_addr}),
          int'({4'b1010, d}));
      chk(rf_wdata == expw, "R11", {tag, " copy data"}, int'(rf_wdata), int'(expw));
      exp_rf[d] = expw;
      @(negedge clk);
      chk(rf[d] == exp_rf[d], rq, {tag, " copy result"}, int'(rf[d]), int'(exp_rf[d]));
    end else if (op == 6'b000010) begin
      rq = w[9] ? "R3" : "R4";
      expw = bit_apply(exp_rf[d], w[9], w[8:5]);
      chk(rf_rd_en && !rf_wr_en && rf_addr == d && !done, "R5", {tag, " bitop read step"},
          int'({rf_rd_en, rf_wr_en, done, rf_addr}), int'({3'b100, d}));
      @(negedge clk);
      chk(rf_wr_en && !rf_rd_en && rf_addr == d && done && !illegal_op, "R9",
          {tag, " bitop write step"}, int'({rf_wr_en, rf_rd_en, done, illegal_op, rf_addr}),
          int'({4'b1010, d}));
      chk(rf_wdata == expw, rq, {tag, " bitop data"}, int'(rf_wdata), int'(expw));
      exp_rf[d] = expw;
      @(negedge clk);
      chk(rf[d] == exp_rf[d], "R5", {tag, " bitop result"}, int'(rf[d]), int'(exp_rf[d]));
    end else begin
      chk(done && illegal_op && !rf_rd_en && !rf_wr_en, "R6", {tag, " illegal step"},
          int'({done, illegal_op, rf_rd_en, rf_wr_en}), 4'b1100);
      @(negedge clk);
    end
    chk(instr_ready && !done && !illegal_op, "R9", {tag, " ready after done"},
        int'({instr_ready, done, illegal_op}), 3'b100);
  endtask

  task automatic compare_all(input string tag);
    int bad = 0;
    for (int i = 0; i < 32; i++) if (rf[i] !== exp_rf[i]) bad++;
    chk(bad == 0, "R5", {tag, " register file mismatches"}, bad, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [15:0] w;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(instr_ready && !rf_rd_en && !rf_wr_en && !done && !illegal_op, "R10",
        "reset state", int'({instr_ready, rf_rd_en, rf_wr_en, done, illegal_op}), 5'b10000);

    for (int i = 0; i < 32; i++) begin
      pre_we = 1'b1; pre_a = 5'(i); pre_d = 16'($urandom);
      exp_rf[i] = pre_d;
      @(negedge clk);
    end
    pre_we = 1'b0;
    @(negedge clk);
    compare_all("preload");

    // directed corners
    exec(mk_copy(3, 3), "R7 self copy");
    exec(mk_copy(31, 0), "R2 copy 31->0");
    exec(mk_bit(1'b1, 15, 7), "R3 set bit15");
    exec(mk_bit(1'b1, 15, 7), "R3 set again");
    exec(mk_bit(1'b0, 0, 7), "R4 clear bit0");
    exec(mk_bit(1'b0, 0, 7), "R4 clear again");
    exec(16'h0000, "R6 opcode 0");
    exec(16'hFFFF, "R6 opcode 63");
    exec(mk_copy(7, 12), "R2 copy after illegal");
    compare_all("directed");

    // random mix
    for (int n = 0; n < 300; n++) begin
      int k;
      k = int'($urandom_range(0, 9));
      if (k < 4)      w = mk_copy(int'($urandom_range(0, 31)), int'($urandom_range(0, 31)));
      else if (k < 8) w = mk_bit(1'($urandom), int'($urandom_range(0, 15)),
                                 int'($urandom_range(0, 31)));
      else begin
        w = 16'($urandom);
        while (w[15:10] == 6'b000001 || w[15:10] == 6'b000010) w = 16'($urandom);
      end
      exec(w, "random");
    end
    compare_all("random");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule